// File: doc/BRIEF.md
# Serial RAM Load Protocol Engine

This block runs the RAM-load phase of a serial boot loader. It sits between a byte receiver, a byte transmitter and a RAM byte-write port. A pulse on `start` moves it out of command wait. It then takes a seven-byte header: a four-byte destination address sent most significant byte first, a two-byte count sent high byte first, and a checksum byte. The header is answered with one acknowledge byte. After a good header, the block writes exactly `count` payload bytes to consecutive RAM addresses. It then takes a payload checksum byte and answers with a final acknowledge.

Every checksum follows the same rule: the 8-bit sum of the covered bytes plus the checksum byte, with carries dropped, must be zero. The acknowledge codes are 0x10 for success, 0x11 for a checksum, count or window failure, and 0x18 for a receive error. Any failure sends the block back to command wait. When `sync_mode` is high, the link is a clocked synchronous one and the receive-error flags are ignored.

The FSM has six states:
- `ST_CMD_WAIT` goes to `ST_HEADER` on `start`.
- `ST_HEADER` goes to `ST_HDR_ACK` when the seventh byte is accepted.
- `ST_HDR_ACK` goes to `ST_PAYLOAD` when a 0x10 is handed over, and to `ST_CMD_WAIT` when any other code is handed over.
- `ST_PAYLOAD` goes to `ST_PAY_SUM` when the last counted byte is accepted.
- `ST_PAY_SUM` goes to `ST_FIN_ACK` when the checksum byte is accepted.
- `ST_FIN_ACK` goes to `ST_CMD_WAIT` when the final code is handed over.

Top module: `ramload_engine`

## Requirements
- R1: After reset the block is in command wait: `rx_ready`, `tx_valid`, `ram_we` and `done` are low, and only a `start` pulse makes `rx_ready` rise.
- R2: Header byte order is fixed. Bytes 0..3 are the address, most significant byte first. Bytes 4..5 are the count, high byte first. Byte 6 is the checksum. The first payload byte is written at the received address.
- R3: The header passes its checksum only if the 8-bit sum of all seven header bytes is 0x00. Otherwise the header acknowledge is 0x11.
- R4: Acknowledge codes are 0x18 (receive error), 0x11 (checksum, count or window failure) and 0x10 (success), and a receive error outranks every other failure. `tx_data` holds steady while `tx_valid` is high and `tx_ready` is low.
- R5: After a 0x18 or 0x11 header acknowledge, the block returns to command wait and accepts no payload byte (`rx_ready` stays low).
- R6: After a 0x10 header acknowledge, exactly `count` payload bytes are written, one per accepted byte, at the start address plus 0, 1, 2 and so on, with the received data.
- R7: The payload checksum byte covers all payload bytes under the same zero-sum rule. The final acknowledge uses the same codes and priority as the header.
- R8: The region must satisfy address ≥ `LOAD_BASE` (default 0x2000_0400) and address + count − 1 ≤ `RAM_LAST` (default 0x2000_FFFF). Otherwise the header acknowledge is 0x11.
- R9: A count of zero gets a 0x11 header acknowledge.
- R10: With `sync_mode` high, `rx_err` is ignored in both phases, and only checksum, count and window decide the code.
- R11: `done` is high for exactly one cycle, the cycle after a 0x10 final acknowledge is handed over, and never after a failing final acknowledge.
- R12: The error and checksum state is cleared on re-entering command wait, so a clean transfer that follows a failed one ends with 0x10 acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Leaves command wait and begins a header |
| sync_mode | input | 1 | High: synchronous link, receive errors ignored |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Engine accepts a received byte |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Receive error attached to this byte |
| tx_valid | output | 1 | Acknowledge byte offered |
| tx_ready | input | 1 | Transmitter takes the acknowledge byte |
| tx_data | output | 8 | Acknowledge code |
| ram_we | output | 1 | RAM byte write strobe |
| ram_addr | output | 32 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| done | output | 1 | One-cycle pulse after a successful load |

## Verification
`rx_ready` and the RAM write strobe are decoded from the state, so a payload byte is written in the same cycle it is accepted. The bench therefore logs writes at the falling edge that comes before each accepting rising edge. Each acknowledge appears on `tx_data` one cycle after its last byte is accepted. `done` rises one cycle after the final acknowledge handshake and falls one cycle later. The bench drives inputs just after the rising edge, samples only on the falling edge, and checks `done` at the first and second falling edges after the handshake. Expected acknowledge codes come from the bench's own sums, window arithmetic and error-priority rule, across swept header and payload error positions, counts and boundary addresses.

// File: rtl/ramload_pkg.sv
`timescale 1ns/1ps
package ramload_pkg;

    localparam logic [7:0] ACK_OK    = 8'h10;
    localparam logic [7:0] ACK_SUM   = 8'h11;
    localparam logic [7:0] ACK_RXERR = 8'h18;

    typedef enum logic [2:0] {
        ST_CMD_WAIT,
        ST_HEADER,
        ST_HDR_ACK,
        ST_PAYLOAD,
        ST_PAY_SUM,
        ST_FIN_ACK
    } ld_state_e;

endpackage

// File: rtl/ramload_sum.sv
`timescale 1ns/1ps
// Running zero-sum and sticky receive-error tracker for one phase.
module ramload_sum (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       take,
    input  logic [7:0] din,
    input  logic       din_err,
    input  logic       ign_err,
    output logic       zero_nx,
    output logic       err_nx
);
    logic [7:0] sum_q;
    logic       err_q;
    logic [7:0] sum_nx;

    assign sum_nx  = sum_q + din;
    assign zero_nx = (sum_nx == 8'h00);
    assign err_nx  = err_q | (din_err & ~ign_err);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            err_q <= 1'b0;
        end else if (clr) begin
            sum_q <= '0;
            err_q <= 1'b0;
        end else if (take) begin
            sum_q <= sum_nx;
            err_q <= err_nx;
        end
    end
endmodule

// File: rtl/ramload_window.sv
`timescale 1ns/1ps
// Checks that [addr, addr+cnt-1] lies inside [LO, HI].
module ramload_window #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter logic [ADDR_W-1:0] LO = '0,
    parameter logic [ADDR_W-1:0] HI = '1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  cnt,
    output logic              ok
);
    logic [ADDR_W:0] last;

    assign last = {1'b0, addr} + (ADDR_W+1)'(cnt) - (ADDR_W+1)'(1);
    assign ok   = (addr >= LO) && (last <= {1'b0, HI});
endmodule

// File: rtl/ramload_engine.sv
`timescale 1ns/1ps
module ramload_engine
    import ramload_pkg::*;
#(
    parameter int unsigned ADDR_BYTES = 4,
    parameter int unsigned CNT_BYTES  = 2,
    parameter logic [8*ADDR_BYTES-1:0] LOAD_BASE = 'h2000_0400,
    parameter logic [8*ADDR_BYTES-1:0] RAM_LAST  = 'h2000_FFFF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    sync_mode,
    input  logic                    rx_valid,
    output logic                    rx_ready,
    input  logic [7:0]              rx_data,
    input  logic                    rx_err,
    output logic                    tx_valid,
    input  logic                    tx_ready,
    output logic [7:0]              tx_data,
    output logic                    ram_we,
    output logic [8*ADDR_BYTES-1:0] ram_addr,
    output logic [7:0]              ram_wdata,
    output logic                    done
);
    localparam int unsigned ADDR_W  = 8*ADDR_BYTES;
    localparam int unsigned CNT_W   = 8*CNT_BYTES;
    localparam int unsigned HDR_LEN = ADDR_BYTES + CNT_BYTES + 1;
    localparam int unsigned IDX_W   = $clog2(HDR_LEN);
    localparam logic [IDX_W-1:0] IDX_LAST     = IDX_W'(HDR_LEN - 1);
    localparam logic [IDX_W-1:0] IDX_ADDR_END = IDX_W'(ADDR_BYTES);
    localparam logic [IDX_W-1:0] IDX_CNT_END  = IDX_W'(ADDR_BYTES + CNT_BYTES);

    ld_state_e         state_q, state_d;
    logic [IDX_W-1:0]  hdr_idx_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  left_q;
    logic [7:0]        ack_q;
    logic              done_q;

    logic       rx_fire, tx_fire, hdr_last;
    logic       sum_clr, zero_nx, err_nx, win_ok;
    logic [7:0] hdr_code, pay_code;

    assign rx_fire  = rx_valid & rx_ready;
    assign tx_fire  = tx_valid & tx_ready;
    assign hdr_last = (state_q == ST_HEADER) && (hdr_idx_q == IDX_LAST);
    assign sum_clr  = (state_q == ST_CMD_WAIT) || (state_q == ST_HDR_ACK);

    ramload_sum u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sum_clr),
        .take    (rx_fire),
        .din     (rx_data),
        .din_err (rx_err),
        .ign_err (sync_mode),
        .zero_nx (zero_nx),
        .err_nx  (err_nx)
    );

    ramload_window #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .LO     (LOAD_BASE),
        .HI     (RAM_LAST)
    ) u_window (
        .addr (addr_q),
        .cnt  (cnt_q),
        .ok   (win_ok)
    );

    // Receive error outranks checksum, count and window failures.
    always_comb begin
        if (err_nx)
            hdr_code = ACK_RXERR;
        else if (!zero_nx || (cnt_q == '0) || !win_ok)
            hdr_code = ACK_SUM;
        else
            hdr_code = ACK_OK;

        if (err_nx)
            pay_code = ACK_RXERR;
        else if (!zero_nx)
            pay_code = ACK_SUM;
        else
            pay_code = ACK_OK;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CMD_WAIT: if (start) state_d = ST_HEADER;
            ST_HEADER:   if (rx_fire && hdr_last) state_d = ST_HDR_ACK;
            ST_HDR_ACK:  if (tx_fire) state_d = (ack_q == ACK_OK) ? ST_PAYLOAD : ST_CMD_WAIT;
            ST_PAYLOAD:  if (rx_fire && (left_q == CNT_W'(1))) state_d = ST_PAY_SUM;
            ST_PAY_SUM:  if (rx_fire) state_d = ST_FIN_ACK;
            ST_FIN_ACK:  if (tx_fire) state_d = ST_CMD_WAIT;
            default:     state_d = ST_CMD_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CMD_WAIT;
        else        state_q <= state_d;
    end

    // Header capture, address walk and acknowledge registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_idx_q <= '0;
            addr_q    <= '0;
            cnt_q     <= '0;
            left_q    <= '0;
            ack_q     <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= (state_q == ST_FIN_ACK) && tx_fire && (ack_q == ACK_OK);
            unique case (state_q)
                ST_CMD_WAIT: hdr_idx_q <= '0;
                ST_HEADER: if (rx_fire) begin
                    hdr_idx_q <= hdr_idx_q + IDX_W'(1);
                    if (hdr_idx_q < IDX_ADDR_END)
                        addr_q <= (addr_q << 8) | ADDR_W'(rx_data);
                    else if (hdr_idx_q < IDX_CNT_END)
                        cnt_q <= (cnt_q << 8) | CNT_W'(rx_data);
                    if (hdr_last)
                        ack_q <= hdr_code;
                end
                ST_HDR_ACK: if (tx_fire) left_q <= cnt_q;
                ST_PAYLOAD: if (rx_fire) begin
                    addr_q <= addr_q + ADDR_W'(1);
                    left_q <= left_q - CNT_W'(1);
                end
                ST_PAY_SUM: if (rx_fire) ack_q <= pay_code;
                ST_FIN_ACK: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rx_ready  = (state_q == ST_HEADER) || (state_q == ST_PAYLOAD) ||
                    (state_q == ST_PAY_SUM);
        tx_valid  = (state_q == ST_HDR_ACK) || (state_q == ST_FIN_ACK);
        tx_data   = ack_q;
        ram_we    = (state_q == ST_PAYLOAD) && rx_valid;
        ram_addr  = addr_q;
        ram_wdata = rx_data;
        done      = done_q;
    end
endmodule

// File: rtl/ramload_engine_chk.sv
`timescale 1ns/1ps
module ramload_engine_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter logic [ADDR_W-1:0] LO = '0,
    parameter logic [ADDR_W-1:0] HI = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              ram_we,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              done
);
    AST_ACK_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_data == 8'h10 || tx_data == 8'h11 || tx_data == 8'h18)); // R4
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R4
    AST_NO_RX_DURING_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_ready && tx_valid)); // R5
    AST_WR_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (rx_valid && rx_ready)); // R6
    AST_WR_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && $past(ram_we)) |-> (ram_addr == $past(ram_addr) + ADDR_W'(1))); // R6
    AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_addr >= LO && ram_addr <= HI)); // R8
    AST_DONE_AFTER_OK: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(tx_valid && tx_ready && tx_data == 8'h10)); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
endmodule

bind ramload_engine ramload_engine_chk #(
    .ADDR_W (ADDR_W),
    .LO     (LOAD_BASE),
    .HI     (RAM_LAST)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .done     (done)
);

// File: tb/ramload_engine_bench.sv
`timescale 1ns/1ps
module ramload_engine_bench;
    localparam logic [31:0] LO = 32'h2000_0400;
    localparam logic [31:0] HI = 32'h2000_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, sync_mode = 1'b0;
    logic        rx_valid = 1'b0, rx_err = 1'b0, tx_ready = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_ready, tx_valid, ram_we, done;
    logic [7:0]  tx_data, ram_wdata;
    logic [31:0] ram_addr;

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 1'b0;

    logic [31:0] log_addr [0:63];
    logic [7:0]  log_data [0:63];
    int          log_n = 0;

    always #2.5 clk = ~clk;

    ramload_engine u_ramload_engine (
        .clk, .rst_n, .start, .sync_mode, .rx_valid, .rx_ready, .rx_data,
        .rx_err, .tx_valid, .tx_ready, .tx_data, .ram_we, .ram_addr,
        .ram_wdata, .done
    );

    // Write log, sampled at the falling edge before each accepting rising edge.
    always @(negedge clk) begin
        if (rst_n && ram_we && log_n < 64) begin
            log_addr[log_n] = ram_addr;
            log_data[log_n] = ram_wdata;
            log_n++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pd(input int i, input logic [31:0] a);
        return 8'(i * 37 + 5) ^ a[7:0];
    endfunction

    // Called at posedge+1; returns at posedge+1 just after acceptance.
    task automatic send_byte(input logic [7:0] d, input bit e);
        rx_valid = 1'b1; rx_data = d; rx_err = e;
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_err = 1'b0;
    endtask

    task automatic get_ack(output logic [7:0] b, input int stall);
        bit steady = 1'b1;
        @(negedge clk);
        while (!tx_valid) @(negedge clk);
        b = tx_data;
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            if (!tx_valid || tx_data != b) steady = 1'b0;
        end
        if (stall > 0) chk(steady, "R4 ack held under backpressure", 32'(tx_data), 32'(b));
        @(posedge clk); #1 tx_ready = 1'b1;
        @(posedge clk); #1 tx_ready = 1'b0;
    endtask

    task automatic run_load(input logic [31:0] a, input logic [15:0] n, input int herr,
                            input bit hbad, input int perr, input bit pbad,
                            input bit sync, input int stall, input string tg);
        logic [7:0] hb [0:6];
        logic [7:0] s, got, exp_h, exp_f, pcs;
        bit win_bad, wr_ok;
        string th, tf;
        hb[0] = a[31:24]; hb[1] = a[23:16]; hb[2] = a[15:8]; hb[3] = a[7:0];
        hb[4] = n[15:8];  hb[5] = n[7:0];
        s = 8'h00;
        for (int i = 0; i < 6; i++) s = s + hb[i];
        hb[6] = 8'h00 - s + (hbad ? 8'h01 : 8'h00);
        win_bad = (a < LO) || (({1'b0, a} + 33'(n) - 33'd1) > {1'b0, HI});
        if (herr >= 0 && !sync)          begin exp_h = 8'h18; th = "R4"; end
        else if (n == 0)                 begin exp_h = 8'h11; th = "R9"; end
        else if (win_bad)                begin exp_h = 8'h11; th = "R8"; end
        else if (hbad)                   begin exp_h = 8'h11; th = "R3"; end
        else                             begin exp_h = 8'h10; th = (herr >= 0) ? "R10" : "R2"; end
        if (tg != "") th = tg;

        sync_mode = sync;
        start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        log_n = 0;
        for (int i = 0; i < 7; i++) send_byte(hb[i], i == herr);
        get_ack(got, stall);
        chk(got == exp_h, {th, " header ack"}, 32'(got), 32'(exp_h));

        if (exp_h != 8'h10) begin
            rx_valid = 1'b1; rx_data = 8'hAA;
            repeat (3) @(negedge clk);
            chk(!rx_ready && log_n == 0, "R5 no payload after failed header", 32'(rx_ready), 32'd0);
            @(posedge clk); #1 rx_valid = 1'b0;
            return;
        end

        s = 8'h00;
        for (int i = 0; i < int'(n); i++) begin
            send_byte(pd(i, a), i == perr);
            s = s + pd(i, a);
        end
        pcs = 8'h00 - s + (pbad ? 8'h01 : 8'h00);
        send_byte(pcs, perr == int'(n));
        if (perr >= 0 && !sync)  begin exp_f = 8'h18; tf = "R7"; end
        else if (pbad)           begin exp_f = 8'h11; tf = "R7"; end
        else                     begin exp_f = 8'h10; tf = (perr >= 0) ? "R10" : "R7"; end
        if (tg != "") tf = tg;
        get_ack(got, stall);
        chk(got == exp_f, {tf, " final ack"}, 32'(got), 32'(exp_f));
        @(negedge clk);
        chk(done == (exp_f == 8'h10), "R11 done after final ack", 32'(done), 32'(exp_f == 8'h10));
        @(negedge clk);
        chk(done == 1'b0, "R11 done lasts one cycle", 32'(done), 32'd0);
        chk(log_n == int'(n), "R6 write count", 32'(log_n), 32'(n));
        wr_ok = 1'b1;
        for (int i = 0; i < log_n; i++)
            if (log_addr[i] != a + 32'(i) || log_data[i] != pd(i, a)) wr_ok = 1'b0;
        chk(wr_ok && log_n > 0 && log_addr[0] == a, "R2 R6 write addresses and data",
            (log_n > 0) ? log_addr[0] : 32'hx, a);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!rx_ready && !tx_valid && !ram_we && !done, "R1 reset outputs",
            {28'd0, rx_ready, tx_valid, ram_we, done}, 32'd0);
        repeat (2) @(negedge clk);
        chk(!rx_ready, "R1 idle without start", 32'(rx_ready), 32'd0);
        @(posedge clk); #1;

        for (int n = 1; n <= 6; n++)
            run_load(LO + 32'(n * 16), 16'(n), -1, 0, -1, 0, 0, n % 3, "");
        run_load(32'h2000_8123, 16'd3, -1, 0, -1, 0, 1, 0, "");

        for (int p = 0; p < 7; p++) begin
            run_load(LO + 32'h100, 16'd2, p, 0, -1, 0, 0, 1, "");
            run_load(LO + 32'h200, 16'd2, p, 0, -1, 0, 1, 0, "");
        end
        run_load(LO, 16'd2, 3, 1, -1, 0, 0, 0, "R4");
        run_load(LO, 16'd2, -1, 1, -1, 0, 0, 0, "");
        run_load(LO, 16'd0, -1, 0, -1, 0, 0, 0, "");
        run_load(LO - 32'd1, 16'd1, -1, 0, -1, 0, 0, 0, "");
        run_load(HI - 32'd3, 16'd4, -1, 0, -1, 0, 0, 0, "R8");
        run_load(HI - 32'd3, 16'd5, -1, 0, -1, 0, 0, 0, "");
        run_load(HI, 16'd1, -1, 0, -1, 0, 0, 0, "R8");
        run_load(HI, 16'd2, -1, 0, -1, 0, 0, 0, "");
        run_load(32'h0000_0000, 16'd1, -1, 0, -1, 0, 0, 0, "");

        for (int p = 0; p <= 3; p++) begin
            run_load(LO + 32'h300, 16'd3, -1, 0, p, 0, 0, 2, "");
            run_load(LO + 32'h400, 16'd3, -1, 0, p, 0, 1, 0, "");
        end
        run_load(LO + 32'h500, 16'd3, -1, 0, -1, 1, 0, 0, "");
        run_load(LO + 32'h500, 16'd3, -1, 0, 1, 1, 0, 0, "R7");

        run_load(LO + 32'h600, 16'd2, 0, 0, -1, 0, 0, 0, "");
        run_load(LO + 32'h600, 16'd2, -1, 0, -1, 0, 0, 0, "R12");
        run_load(LO + 32'h700, 16'd2, -1, 0, 0, 0, 0, 0, "");
        run_load(LO + 32'h700, 16'd2, -1, 0, -1, 0, 0, 0, "R12");
        run_load(LO + 32'h800, 16'd2, -1, 0, -1, 1, 0, 0, "");
        run_load(LO + 32'h800, 16'd2, -1, 0, -1, 0, 0, 0, "R12");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule